// File: doc/BRIEF.md
# I/O Condition Code and Interrupt Status Generator

This block lives in a disk controller attachment and answers the host. When the host issues an I/O instruction, the block returns a 3-bit condition code one cycle later. The code says whether the command was taken, refused, or could not be seen at all. When the command is taken and needs no pending work, the block also pulses a start strobe for the control-block fetch.

The block also collects completion, attention and exception events from the rest of the attachment. From them it raises an interrupt request. While the request is up, it presents a 3-bit interrupt code and a 16-bit identification word. The word carries an information byte and a device address. A unit-busy state starts when a command that ends with an interrupt is taken. It ends when the host accepts the interrupt that closes that operation. Exception conditions are OR-ed into a status byte until that byte is delivered.

Top module: `iocc_status_gen`

## Requirements
- R1: After reset, `cc_valid`, `dcb_fetch` and `irq_req` are 0.
- R2: A `cmd_valid` pulse gives a one-cycle `cc_valid` on the next cycle. The `cc_code` is chosen by this priority: device not attached 0, bus parity error 5, busy after reset 2, controller busy 6, unit busy 1, command reject 3, accepted 7. Code 4 never appears.
- R3: Unit-busy is set when a command with `cmd_ends_irq`=1 is accepted. It is cleared when the host accepts an exception or device-end interrupt. Commands issued while unit-busy get code 1. A command taken with `cmd_ends_irq`=0 does not set unit-busy.
- R4: A command gets code 3 when it is not in the command set, when the unit state is wrong, or when a parameter is bad. A rejected command gives no `dcb_fetch`. `dcb_fetch` pulses together with `cc_valid` only for code 7.
- R5: The interrupt code follows the pending conditions: exception 2, device end 3, attention 4, attention with exception 6, attention with device end 7, controller end 0. Codes 1 and 5 never appear.
- R6: Reporting code 6 leaves a controller-end interrupt pending, with code 0. Its information byte is zero, and it carries `LOW_ADDR` instead of `DEV_ADDR`. It has the lowest priority of all interrupts.
- R7: `irq_id[15:8]` is the information byte, and its bit 0 is `irq_id[15]`. `irq_id[7]` is always 0. `irq_id[6:0]` is the device address.
- R8: On a device-end interrupt, the information byte is {permissive, scan-not-equal, scan-equal, 5'b0}. These flags are latched from the most recent `op_done` only. On an attention-only interrupt, the byte is zero.
- R9: Every `exc_set` bit is OR-ed into the status byte. The status byte appears unchanged as the information byte of an exception interrupt. It clears when that interrupt is accepted. Bits that arrive during the accept cycle are kept.
- R10: Exception outranks device end, including when both arrive in the same cycle. Accepting an exception interrupt also discards a pending device end. Attention merges into codes 6 and 7 and is cleared with them.
- R11: `irq_ack` while `irq_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_valid | input | 1 | host issues an I/O instruction this cycle |
| dev_attached | input | 1 | addressed unit is present |
| bus_parity_err | input | 1 | parity error on the data bus for this instruction |
| rst_recover | input | 1 | unit still recovering from a reset |
| ctrl_busy | input | 1 | shared controller is busy |
| cmd_known | input | 1 | command is in the command set |
| cmd_state_ok | input | 1 | unit state allows this command |
| cmd_param_ok | input | 1 | parameters (address alignment, function/modifier) are legal |
| cmd_ends_irq | input | 1 | command terminates with an interrupt |
| cc_valid | output | 1 | instruction-time condition code valid |
| cc_code | output | 3 | instruction-time condition code |
| dcb_fetch | output | 1 | start control-block fetch |
| op_done | input | 1 | operation completed normally |
| op_permissive | input | 1 | temporary error logged for the completing operation |
| op_scan_ne | input | 1 | scan condition not met |
| op_scan_eq | input | 1 | scan condition met |
| attn_evt | input | 1 | unit became ready |
| exc_set | input | 8 | exception conditions; bit 7 is status-byte bit 0 |
| irq_ack | input | 1 | host accepts the interrupt |
| irq_req | output | 1 | interrupt request |
| irq_cc | output | 3 | interrupt-time condition code |
| irq_id | output | 16 | interrupt identification word |

## Verification
The checker takes two things for granted. First, each command context flag is meaningful only in a cycle where `cmd_valid` is high. Second, `irq_ack` is a single-cycle pulse. The stimulus drives every input away from the clock edge and holds each command and each event for exactly one cycle. It drives `irq_ack` for one cycle, and except in the R11 case, only while a request is up. Event pulses are issued only after the previous interrupt is checked and accepted. The single exceptions are the deliberate merge and same-cycle cases.

// File: rtl/iocc_pkg.sv
package iocc_pkg;
  localparam int CC_W   = 3;
  localparam int INFO_W = 8;
  localparam int ADDR_W = 7;
  localparam int ID_W   = INFO_W + 1 + ADDR_W;

  typedef enum logic [CC_W-1:0] {
    IC_NOT_ATT   = 3'd0,
    IC_BUSY      = 3'd1,
    IC_BUSY_RST  = 3'd2,
    IC_REJECT    = 3'd3,
    IC_PARITY    = 3'd5,
    IC_CTRL_BUSY = 3'd6,
    IC_ACCEPT    = 3'd7
  } ins_cc_e;

  typedef enum logic [CC_W-1:0] {
    XC_CTRL_END = 3'd0,
    XC_EXC      = 3'd2,
    XC_DEV_END  = 3'd3,
    XC_ATTN     = 3'd4,
    XC_ATTN_EXC = 3'd6,
    XC_ATTN_DE  = 3'd7
  } irq_cc_e;

  typedef struct packed {
    logic attached;
    logic parity_err;
    logic rst_recover;
    logic ctrl_busy;
    logic unit_busy;
    logic known;
    logic state_ok;
    logic param_ok;
  } cmd_ctx_t;

  // Instruction-time code selection in fixed priority order.
  function automatic ins_cc_e pick_ins_cc(input cmd_ctx_t c);
    if (!c.attached)                              return IC_NOT_ATT;
    else if (c.parity_err)                        return IC_PARITY;
    else if (c.rst_recover)                       return IC_BUSY_RST;
    else if (c.ctrl_busy)                         return IC_CTRL_BUSY;
    else if (c.unit_busy)                         return IC_BUSY;
    else if (!(c.known && c.state_ok && c.param_ok)) return IC_REJECT;
    else                                          return IC_ACCEPT;
  endfunction

  // Interrupt-time code: exception over device end, attention merged,
  // controller end last.
  function automatic irq_cc_e pick_irq_cc(input logic exc, input logic de,
                                          input logic att);
    if (exc)      return att ? XC_ATTN_EXC : XC_EXC;
    else if (de)  return att ? XC_ATTN_DE  : XC_DEV_END;
    else if (att) return XC_ATTN;
    else          return XC_CTRL_END;
  endfunction

  function automatic logic [INFO_W-1:0] de_info(input logic perm,
                                                input logic sne,
                                                input logic seq);
    return {perm, sne, seq, {(INFO_W-3){1'b0}}};
  endfunction

  function automatic logic [ID_W-1:0] pack_id(input logic [INFO_W-1:0] info,
                                              input logic [ADDR_W-1:0] addr);
    return {info, 1'b0, addr};
  endfunction
endpackage

// File: rtl/iocc_cmd_eval.sv
module iocc_cmd_eval
  import iocc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  cmd_ctx_t        ctx_in,
  input  logic            cmd_ends_irq,
  input  logic            term_ack,
  output logic            cc_valid,
  output logic [CC_W-1:0] cc_code,
  output logic            dcb_fetch,
  output logic            busy_q,
  output logic            ce_owe_set
);
  cmd_ctx_t ctx;
  ins_cc_e  code_d;
  logic     accept_irq_cmd;

  always_comb begin
    ctx           = ctx_in;
    ctx.unit_busy = busy_q;
    code_d        = pick_ins_cc(ctx);
  end

  assign accept_irq_cmd = cmd_valid && (code_d == IC_ACCEPT) && cmd_ends_irq;
  assign ce_owe_set     = cc_valid && (cc_code == IC_CTRL_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_valid  <= 1'b0;
      cc_code   <= '0;
      dcb_fetch <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      cc_valid  <= cmd_valid;
      if (cmd_valid) cc_code <= code_d;
      dcb_fetch <= cmd_valid && (code_d == IC_ACCEPT);
      if (accept_irq_cmd)  busy_q <= 1'b1;
      else if (term_ack)   busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/iocc_irq_track.sv
module iocc_irq_track
  import iocc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_done,
  input  logic              op_permissive,
  input  logic              op_scan_ne,
  input  logic              op_scan_eq,
  input  logic              attn_evt,
  input  logic [INFO_W-1:0] exc_set,
  input  logic              ce_owe_set,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [CC_W-1:0]   irq_cc,
  output logic [INFO_W-1:0] irq_info,
  output logic              ce_sel,
  output logic              take,
  output logic              term_ack
);
  logic [INFO_W-1:0] isb_q, dinfo_q;
  logic              de_q, att_q, ce_q;
  logic              exc_pend;
  logic              clr_isb, clr_de, clr_att, clr_ce;
  irq_cc_e           code;

  assign exc_pend = |isb_q;
  assign irq_req  = exc_pend || de_q || att_q || ce_q;
  assign code     = pick_irq_cc(exc_pend, de_q, att_q);
  assign irq_cc   = code;
  assign ce_sel   = (code == XC_CTRL_END);
  assign take     = irq_ack && irq_req;

  assign clr_isb  = take && exc_pend;
  assign clr_de   = take && (exc_pend || de_q);
  assign clr_att  = take && att_q;
  assign clr_ce   = take && !exc_pend && !de_q && !att_q;
  assign term_ack = clr_de;

  always_comb begin
    if (exc_pend)  irq_info = isb_q;
    else if (de_q) irq_info = dinfo_q;
    else           irq_info = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isb_q   <= '0;
      dinfo_q <= '0;
      de_q    <= 1'b0;
      att_q   <= 1'b0;
      ce_q    <= 1'b0;
    end else begin
      isb_q <= (clr_isb ? '0 : isb_q) | exc_set;
      de_q  <= (de_q && !clr_de) || op_done;
      att_q <= (att_q && !clr_att) || attn_evt;
      ce_q  <= (ce_q && !clr_ce) || ce_owe_set;
      if (op_done) dinfo_q <= de_info(op_permissive, op_scan_ne, op_scan_eq);
    end
  end
endmodule

// File: rtl/iocc_status_gen.sv
module iocc_status_gen
  import iocc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h15,
  parameter logic [ADDR_W-1:0] LOW_ADDR = 7'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              dev_attached,
  input  logic              bus_parity_err,
  input  logic              rst_recover,
  input  logic              ctrl_busy,
  input  logic              cmd_known,
  input  logic              cmd_state_ok,
  input  logic              cmd_param_ok,
  input  logic              cmd_ends_irq,
  output logic              cc_valid,
  output logic [CC_W-1:0]   cc_code,
  output logic              dcb_fetch,
  input  logic              op_done,
  input  logic              op_permissive,
  input  logic              op_scan_ne,
  input  logic              op_scan_eq,
  input  logic              attn_evt,
  input  logic [INFO_W-1:0] exc_set,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [CC_W-1:0]   irq_cc,
  output logic [ID_W-1:0]   irq_id
);
  cmd_ctx_t          ctx;
  logic              busy_q, term_ack, take, ce_owe_set, ce_sel;
  logic [INFO_W-1:0] irq_info;

  always_comb begin
    ctx             = '0;
    ctx.attached    = dev_attached;
    ctx.parity_err  = bus_parity_err;
    ctx.rst_recover = rst_recover;
    ctx.ctrl_busy   = ctrl_busy;
    ctx.known       = cmd_known;
    ctx.state_ok    = cmd_state_ok;
    ctx.param_ok    = cmd_param_ok;
  end

  iocc_cmd_eval u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .ctx_in       (ctx),
    .cmd_ends_irq (cmd_ends_irq),
    .term_ack     (term_ack),
    .cc_valid     (cc_valid),
    .cc_code      (cc_code),
    .dcb_fetch    (dcb_fetch),
    .busy_q       (busy_q),
    .ce_owe_set   (ce_owe_set)
  );

  iocc_irq_track u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_done       (op_done),
    .op_permissive (op_permissive),
    .op_scan_ne    (op_scan_ne),
    .op_scan_eq    (op_scan_eq),
    .attn_evt      (attn_evt),
    .exc_set       (exc_set),
    .ce_owe_set    (ce_owe_set),
    .irq_ack       (irq_ack),
    .irq_req       (irq_req),
    .irq_cc        (irq_cc),
    .irq_info      (irq_info),
    .ce_sel        (ce_sel),
    .take          (take),
    .term_ack      (term_ack)
  );

  assign irq_id = pack_id(irq_info, ce_sel ? LOW_ADDR : DEV_ADDR);
endmodule

// File: rtl/iocc_status_chk.sv
module iocc_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        dev_attached,
  input logic        bus_parity_err,
  input logic        rst_recover,
  input logic        ctrl_busy,
  input logic        cc_valid,
  input logic [2:0]  cc_code,
  input logic        dcb_fetch,
  input logic        irq_req,
  input logic [2:0]  irq_cc,
  input logic [15:0] irq_id,
  input logic        busy_q
);
  // R2
  no_cc4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_valid |-> (cc_code != 3'd4));

  // R2
  cc_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> cc_valid);

  // R3
  busy_reports_1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_valid && dev_attached && !bus_parity_err && !rst_recover
     && !ctrl_busy) |=> (cc_valid && cc_code == 3'd1));

  // R4
  fetch_only_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dcb_fetch |-> (cc_valid && cc_code == 3'd7));

  // R5
  no_irq_cc_1_5_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_cc != 3'd1 && irq_cc != 3'd5));

  // R6
  ctrl_end_info_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_cc == 3'd0) |-> (irq_id[15:8] == 8'h00));

  // R7
  id_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_id[7] == 1'b0);

  // R9
  exc_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && (irq_cc == 3'd2 || irq_cc == 3'd6)) |-> (irq_id[15:8] != 8'h00));
endmodule

bind iocc_status_gen iocc_status_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .dev_attached   (dev_attached),
  .bus_parity_err (bus_parity_err),
  .rst_recover    (rst_recover),
  .ctrl_busy      (ctrl_busy),
  .cc_valid       (cc_valid),
  .cc_code        (cc_code),
  .dcb_fetch      (dcb_fetch),
  .irq_req        (irq_req),
  .irq_cc         (irq_cc),
  .irq_id         (irq_id),
  .busy_q         (busy_q)
);

// File: tb/iocc_status_gen_tb_top.sv
module iocc_status_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, dev_attached = 1, bus_parity_err = 0, rst_recover = 0;
  logic        ctrl_busy = 0, cmd_known = 1, cmd_state_ok = 1, cmd_param_ok = 1;
  logic        cmd_ends_irq = 0;
  logic        cc_valid, dcb_fetch, irq_req;
  logic [2:0]  cc_code, irq_cc;
  logic        op_done = 0, op_permissive = 0, op_scan_ne = 0, op_scan_eq = 0;
  logic        attn_evt = 0, irq_ack = 0;
  logic [7:0]  exc_set = 8'h00;
  logic [15:0] irq_id;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  iocc_status_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .dev_attached(dev_attached),
    .bus_parity_err(bus_parity_err), .rst_recover(rst_recover),
    .ctrl_busy(ctrl_busy), .cmd_known(cmd_known), .cmd_state_ok(cmd_state_ok),
    .cmd_param_ok(cmd_param_ok), .cmd_ends_irq(cmd_ends_irq),
    .cc_valid(cc_valid), .cc_code(cc_code), .dcb_fetch(dcb_fetch),
    .op_done(op_done), .op_permissive(op_permissive), .op_scan_ne(op_scan_ne),
    .op_scan_eq(op_scan_eq), .attn_evt(attn_evt), .exc_set(exc_set),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_cc(irq_cc), .irq_id(irq_id)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pop expected instruction codes as the design reports them.
  always @(negedge clk) begin
    if (rst_n && cc_valid && !finished) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected cc_valid", {13'b0, cc_code}, 16'hffff);
      end else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cc_code == e, t, {13'b0, cc_code}, {13'b0, e});
        // R4: fetch strobe only with an accepted command
        chk(dcb_fetch == (e == 3'd7), "R4 dcb_fetch", {15'b0, dcb_fetch},
            {15'b0, (e == 3'd7)});
      end
    end else if (rst_n && !finished && dcb_fetch) begin
      chk(1'b0, "R4 stray dcb_fetch", 16'h1, 16'h0);
    end
  end

  // Driver: one-cycle command, expected code pushed to the scoreboard.
  task automatic issue(input bit att, input bit par, input bit rr, input bit cb,
                       input bit kn, input bit st, input bit pm, input bit ei,
                       input logic [2:0] exp, input string tag);
    @(negedge clk);
    dev_attached = att; bus_parity_err = par; rst_recover = rr; ctrl_busy = cb;
    cmd_known = kn; cmd_state_ok = st; cmd_param_ok = pm; cmd_ends_irq = ei;
    cmd_valid = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b0; dev_attached = 1; bus_parity_err = 0; rst_recover = 0;
    ctrl_busy = 0; cmd_known = 1; cmd_state_ok = 1; cmd_param_ok = 1;
    cmd_ends_irq = 0;
  endtask

  task automatic good_cmd(input bit ei, input logic [2:0] exp, input string tag);
    issue(1, 0, 0, 0, 1, 1, 1, ei, exp, tag);
  endtask

  task automatic ev(input bit done, input bit perm, input bit sne, input bit seq,
                    input bit att, input logic [7:0] exc);
    @(negedge clk);
    op_done = done; op_permissive = perm; op_scan_ne = sne; op_scan_eq = seq;
    attn_evt = att; exc_set = exc;
    @(negedge clk);
    op_done = 0; op_permissive = 0; op_scan_ne = 0; op_scan_eq = 0;
    attn_evt = 0; exc_set = 8'h00;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic chk_irq(input bit req, input logic [2:0] cc,
                         input logic [15:0] id, input string tag);
    chk(irq_req == req, {tag, " irq_req"}, {15'b0, irq_req}, {15'b0, req});
    if (req) begin
      chk(irq_cc == cc, {tag, " irq_cc"}, {13'b0, irq_cc}, {13'b0, cc});
      chk(irq_id == id, {tag, " irq_id"}, irq_id, id);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cc_valid == 0 && dcb_fetch == 0 && irq_req == 0, "R1 reset outputs",
        {13'b0, cc_valid, dcb_fetch, irq_req}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_req == 0, "R1 idle after reset", {15'b0, irq_req}, 16'h0);

    // R2 priority of instruction codes
    issue(0, 1, 1, 1, 0, 0, 0, 1, 3'd0, "R2 not attached");
    issue(1, 1, 1, 1, 0, 0, 0, 1, 3'd5, "R2 parity");
    issue(1, 0, 1, 1, 0, 0, 0, 1, 3'd2, "R2 busy after reset");
    // R4 reject reasons
    issue(1, 0, 0, 0, 0, 1, 1, 1, 3'd3, "R4 unknown command");
    issue(1, 0, 0, 0, 1, 0, 1, 1, 3'd3, "R4 bad state");
    issue(1, 0, 0, 0, 1, 1, 0, 1, 3'd3, "R4 bad parameter");
    // R3 non-interrupt command does not set busy
    good_cmd(0, 3'd7, "R3 accept no-irq");
    good_cmd(0, 3'd7, "R3 accept again");
    // R3 busy span
    good_cmd(1, 3'd7, "R3 accept irq cmd");
    good_cmd(0, 3'd1, "R3 busy");
    issue(1, 0, 0, 0, 0, 1, 1, 0, 3'd1, "R3 busy beats reject");
    // R8 device end info: permissive + scan equal
    ev(1, 1, 0, 1, 0, 8'h00);
    chk_irq(1, 3'd3, 16'hA015, "R8 device end");
    ack();
    chk_irq(0, 3'd0, 16'h0, "R3 after accept");
    good_cmd(0, 3'd7, "R3 busy cleared");

    // R6 controller end
    issue(1, 0, 0, 1, 1, 1, 1, 0, 3'd6, "R6 controller busy");
    @(negedge clk);
    chk_irq(1, 3'd0, 16'h0010, "R6 controller end");
    ack();
    chk_irq(0, 3'd0, 16'h0, "R6 cleared");

    // R5 attention alone
    ev(0, 0, 0, 0, 1, 8'h00);
    chk_irq(1, 3'd4, 16'h0015, "R5 attention");
    ack();

    // R9 accumulation, R10 merging
    good_cmd(1, 3'd7, "R9 accept irq cmd");
    ev(0, 0, 0, 0, 0, 8'h40);
    ev(0, 0, 0, 0, 0, 8'h02);
    chk_irq(1, 3'd2, 16'h4215, "R9 accumulated status");
    ev(0, 0, 0, 0, 1, 8'h00);
    chk_irq(1, 3'd6, 16'h4215, "R5 attention with exception");
    ev(1, 0, 1, 0, 0, 8'h00);
    chk_irq(1, 3'd6, 16'h4215, "R10 exception over device end");
    ack();
    chk_irq(0, 3'd0, 16'h0, "R10 device end discarded");
    good_cmd(0, 3'd7, "R3 exception ends busy");

    // R5 attention with device end; R8 scan-not-equal
    ev(1, 0, 1, 0, 1, 8'h00);
    chk_irq(1, 3'd7, 16'h4015, "R5 attention with device end");
    ack();
    ev(1, 0, 0, 0, 0, 8'h00);
    chk_irq(1, 3'd3, 16'h0015, "R8 scan flags last op only");
    ack();

    // R11 stray accept
    ack();
    chk_irq(0, 3'd0, 16'h0, "R11 stray ack");
    // R10 same-cycle exception and device end; R9 cleared earlier
    ev(1, 1, 0, 1, 0, 8'h01);
    chk_irq(1, 3'd2, 16'h0115, "R10 same cycle");
    ack();
    chk_irq(0, 3'd0, 16'h0, "R9 status cleared");

    // R9 bits arriving during the accept cycle are kept
    ev(0, 0, 0, 0, 0, 8'h80);
    @(negedge clk);
    irq_ack = 1'b1; exc_set = 8'h04;
    @(negedge clk);
    irq_ack = 1'b0; exc_set = 8'h00;
    chk_irq(1, 3'd2, 16'h0415, "R9 set during accept");
    ack();

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 16'h0);
    finish_run();
  end
endmodule